// File: doc/BRIEF.md
# Tiled View Address Generator

This unit turns a pixel coordinate inside a two-dimensional tiled container into the bus address that selects one of eight rotated or mirrored views of that container. Each request carries an element format, a three-bit orientation code and the X and Y coordinates. The unit first checks the coordinates against the container extent for that format. A coordinate that passes is mirrored and optionally transposed, then scaled to the element size. The format and the orientation are then placed in the top address bits.

The unit also returns the line stride of the selected view, which a display or DMA engine needs to step from one row of the view to the next. A request is accepted whenever the input strobe is high. The address and stride appear one clock later together with an output strobe. Between requests the outputs keep their last value.

The container is 2^CW_BITS elements wide and 2^CH_BITS high in 8-bit units, 14 and 13 by default. The coordinate part of the address therefore always fits below the five packed bits.

Top module: `tiled_view_addr`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid`, `addr` and `stride` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `addr` and `stride` update only in that cycle and hold their value otherwise.
- R3: For an address that passes the range check, bits [28:27] carry the format code: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is page mode.
- R4: For an address that passes the range check, bits [31:29] carry the orientation code unchanged. The codes are 0 for 0°, 1 for 180° mirrored, 2 for 0° mirrored, 3 for 180°, 4 for 270° mirrored, 5 for 270°, 6 for 90° and 7 for 90° mirrored.
- R5: Each format has a shift pair (sx, sy): (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit. The X mask is 2^(CW_BITS−sx)−1 and the Y mask is 2^(CH_BITS−sy)−1. If X exceeds its mask, or Y exceeds its mask, the whole address is 0.
- R6: Orientation bit 0 set replaces X by X XOR the X mask. Orientation bit 1 set replaces Y by Y XOR the Y mask.
- R7: With orientation bit 2 clear, the offset is Y·2^(X bits) + X. With bit 2 set, it is X·2^(Y bits) + Y. The values used are the mirrored ones.
- R8: The offset is shifted left by sx+sy and occupies address bits [26:0].
- R9: `stride` is 2^(CH_BITS+sx) when orientation bit 2 is set, and 2^(CW_BITS+sy) otherwise. It does not depend on the range check.
- R10: Page mode uses the shift pair (PG_SX, PG_SY), 6 and 7 by default. Its X mask is then 255 and its Y mask 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| fmt | input | 2 | Element format code |
| orient | input | 3 | View code: bit0 X invert, bit1 Y invert, bit2 XY swap |
| x | input | COORD_W | X coordinate in elements |
| y | input | COORD_W | Y coordinate in elements |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| addr | output | CW_BITS+CH_BITS+5 | View address |
| stride | output | CW_BITS+CH_BITS+5 | Line stride of the view in bytes |

## Verification
Both `addr` and `stride` pass through a single register, so each result is due exactly one clock after the edge that sees `in_valid`. The bench drives a request on a falling edge. It reads `out_valid`, `addr` and `stride` on the next falling edge, so each value is read half a period after the register that produces it. A cycle with the strobe low and different inputs follows each request. On the next falling edge the bench confirms that the previous results are still held and that `out_valid` is low.

// File: rtl/tiled_view_addr.sv
module tiled_view_addr #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int COORD_W = 16,
  parameter int PG_SX   = 6,
  parameter int PG_SY   = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [1:0]                      fmt,
  input  logic [2:0]                      orient,
  input  logic [COORD_W-1:0]              x,
  input  logic [COORD_W-1:0]              y,
  output logic                            out_valid,
  output logic [CW_BITS+CH_BITS+4:0]      addr,
  output logic [CW_BITS+CH_BITS+4:0]      stride
);
  localparam int OFF_W  = CW_BITS + CH_BITS;
  localparam int ADDR_W = OFF_W + 5;

  logic [5:0]        sx, sy, xbits, ybits, algn;
  logic [ADDR_W-1:0] xe, ye, xmask, ymask, xm, ym, offs, addr_n, stride_n;
  logic [OFF_W-1:0]  coord;
  logic              in_rng;

  always_comb begin
    case (fmt)
      2'd0:    begin sx = 6'd0;         sy = 6'd0;         end
      2'd1:    begin sx = 6'd0;         sy = 6'd1;         end
      2'd2:    begin sx = 6'd1;         sy = 6'd1;         end
      default: begin sx = 6'(PG_SX);    sy = 6'(PG_SY);    end
    endcase
  end

  assign xbits = 6'(CW_BITS) - sx;
  assign ybits = 6'(CH_BITS) - sy;
  assign algn  = sx + sy;
  assign xmask = (ADDR_W'(1) << xbits) - ADDR_W'(1);
  assign ymask = (ADDR_W'(1) << ybits) - ADDR_W'(1);
  assign xe    = ADDR_W'(x);
  assign ye    = ADDR_W'(y);
  assign in_rng = (xe <= xmask) && (ye <= ymask);
  assign xm    = orient[0] ? (xe ^ xmask) : xe;
  assign ym    = orient[1] ? (ye ^ ymask) : ye;
  assign offs  = orient[2] ? ((xm << ybits) + ym) : ((ym << xbits) + xm);
  assign coord = OFF_W'(offs << algn);
  assign addr_n = in_rng ? {orient, fmt, coord} : '0;
  assign stride_n = orient[2] ? (ADDR_W'(1) << (6'(CH_BITS) + sx))
                              : (ADDR_W'(1) << (6'(CW_BITS) + sy));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr      <= '0;
      stride    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr   <= addr_n;
        stride <= stride_n;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(addr) && $stable(stride));
  // R3
  fmt_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && addr != '0 |-> addr[OFF_W+1:OFF_W] == $past(fmt));
  // R4
  view_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && addr != '0 |-> addr[ADDR_W-1:OFF_W+2] == $past(orient));
  // R8
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && addr[OFF_W+1:OFF_W] == 2'd2 |-> addr[1:0] == 2'b00);
  // R9
  stride_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(stride) == 1);
endmodule

// File: tb/tiled_view_addr_tb.sv
`timescale 1ns/1ps
module tiled_view_addr_tb;
  localparam int CW = 14, CH = 13, CWID = 16, AW = CW + CH + 5;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] fmt = '0;
  logic [2:0] orient = '0;
  logic [CWID-1:0] x = '0, y = '0;
  logic out_valid;
  logic [AW-1:0] addr, stride;
  int nvec = 0, nbad = 0;

  always #10 clk = ~clk;

  tiled_view_addr u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt),
    .orient(orient), .x(x), .y(y), .out_valid(out_valid), .addr(addr), .stride(stride));

  function automatic int sxf(input logic [1:0] f);
    case (f) 2'd0: return 0; 2'd1: return 0; 2'd2: return 1; default: return 6; endcase
  endfunction
  function automatic int syf(input logic [1:0] f);
    case (f) 2'd0: return 0; 2'd1: return 1; 2'd2: return 1; default: return 7; endcase
  endfunction

  function automatic logic [AW-1:0] model_addr(input logic [1:0] f, input logic [2:0] o,
                                               input longint xi, input longint yi);
    longint wx = CW - sxf(f), hy = CH - syf(f);
    longint mx = (longint'(1) << wx) - 1, my = (longint'(1) << hy) - 1;
    longint a, b, off;
    if (xi > mx || yi > my) return '0;
    a = o[0] ? (mx - xi) : xi;
    b = o[1] ? (my - yi) : yi;
    off = o[2] ? (a * (longint'(1) << hy) + b) : (b * (longint'(1) << wx) + a);
    off = off * (longint'(1) << (sxf(f) + syf(f)));
    return AW'(longint'(o) * (longint'(1) << 29) + longint'(f) * (longint'(1) << 27) + off);
  endfunction

  function automatic logic [AW-1:0] model_stride(input logic [1:0] f, input logic [2:0] o);
    return o[2] ? AW'(longint'(1) << (CH + sxf(f))) : AW'(longint'(1) << (CW + syf(f)));
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input string tag, input logic [1:0] f, input logic [2:0] o,
                     input int xi, input int yi);
    logic [AW-1:0] ea, es;
    ea = model_addr(f, o, longint'(xi), longint'(yi));
    es = model_stride(f, o);
    @(negedge clk);
    fmt = f; orient = o; x = CWID'(xi); y = CWID'(yi); in_valid = 1'b1;
    @(negedge clk);
    chk({tag, " R2 valid"}, AW'(out_valid), AW'(1));
    chk({tag, " addr"}, addr, ea);
    chk({tag, " R9 stride"}, stride, es);
    in_valid = 1'b0; fmt = ~f; orient = ~o; x = ~x; y = ~y;
    @(negedge clk);
    chk("R2 idle valid", AW'(out_valid), AW'(0));
    chk("R2 addr hold", addr, ea);
    chk("R2 stride hold", stride, es);
  endtask

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int unsigned dummy;
    dummy = $urandom(32'h5eed1);
    repeat (3) @(negedge clk);
    chk("R1 valid", AW'(out_valid), AW'(0));
    chk("R1 addr", addr, '0);
    chk("R1 stride", stride, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after", AW'(out_valid), AW'(0));
    chk("R1 addr after", addr, '0);

    req("R7 plain", 2'd0, 3'd0, 3, 2);
    chk("R7 literal", addr, AW'(32'h0000_8003));
    chk("R9 literal", stride, AW'(32'h0000_4000));
    req("R6 R7 full flip", 2'd0, 3'd7, 0, 0);
    chk("R6 literal", addr, AW'(32'hE7FF_FFFF));
    chk("R9 swap literal", stride, AW'(32'h0000_2000));
    req("R8 32bit", 2'd2, 3'd0, 1, 0);
    chk("R3 R8 literal", addr, AW'(32'h1000_0004));
    req("R5 x at mask", 2'd0, 3'd2, 16383, 8191);
    req("R5 x over", 2'd0, 3'd0, 16384, 0);
    chk("R5 zero", addr, '0);
    req("R5 y over 16b", 2'd1, 3'd5, 0, 4096);
    chk("R5 zero 16b", addr, '0);
    req("R5 y at mask 16b", 2'd1, 3'd5, 16383, 4095);
    req("R5 x over 32b", 2'd2, 3'd1, 8192, 0);
    chk("R5 zero 32b", addr, '0);
    req("R10 page max", 2'd3, 3'd6, 255, 63);
    req("R10 page x over", 2'd3, 3'd3, 256, 0);
    chk("R10 zero", addr, '0);
    req("R10 page y over", 2'd3, 3'd4, 0, 64);
    chk("R10 zero y", addr, '0);
    for (int o = 0; o < 8; o++)
      for (int f = 0; f < 4; f++)
        req("R4 R3 sweep", 2'(f), 3'(o), 5, 3);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] f;
      int lim_x, lim_y, xi, yi;
      f = 2'($urandom);
      lim_x = (1 << (CW - sxf(f))) + 2;
      lim_y = (1 << (CH - syf(f))) + 2;
      xi = ($urandom % 4 == 0) ? lim_x - 1 - int'($urandom % 4) : int'($urandom % lim_x);
      yi = ($urandom % 4 == 0) ? lim_y - 1 - int'($urandom % 4) : int'($urandom % lim_y);
      req("R5 R6 R7 R8 random", f, 3'($urandom), xi, yi);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule